// File: doc/BRIEF.md
# Parallel Device Bus Read Sequencer

This block runs read cycles on a multiplexed address/data bus shared by flash, NAND or FPGA style peripherals. Each chip-select line owns a set of timing values counted in clock cycles: the delay to the first data sample, the spacing of later burst beats, the output-enable setup, the chip-select hold, the turn-off gap and the address-to-sample skew. A requester hands over a chip select, a start address and a burst length. The block then pulses the address-latch strobe while driving the address onto the shared bus, asserts the chosen chip select, opens output enable, steps the low three address bits and presents each sampled word with a valid pulse.

Output enable and chip select are released on separate schedules. A new request is taken only after the turn-off gap has expired. A request whose timing values break a required ordering is refused at once, and an error flag is raised in the same cycle.

Top module: `par_rd_seq`

## Requirements
- R1: After reset and whenever idle, `req_ready` is 1, `ale_n`, `oe_n` and every bit of `cs_n` are 1, `ad_oe` is 0 and `rd_valid` is 0.
- R2: The cycle after an accepting clock edge (cycle 0) has `ale_n` = 0 for that cycle only, `cs_n` bit `req_cs` low with all others high, and `ad_out` equal to the request address with `ad_oe` = 1 in that cycle only.
- R3: The first beat is sampled in cycle acc_first+1, that is, acc_first cycles after the strobe is negated. `rd_valid` is 1 in each sample cycle and `rd_data` equals `ad_in` in that cycle.
- R4: Each further beat is sampled acc_next cycles after the previous one. A burst has `req_beats_m1`+1 beats.
- R5: `oe_n` first goes low in cycle rd_setup. It stays low up to and including the last sample, and rd_setup never moves the first sample.
- R6: `oe_n` returns to 1 in the cycle right after the last sample, whatever rd_hold is.
- R7: The selected chip select stays low through rd_hold cycles after the last sample and goes high rd_hold+1 cycles after it.
- R8: `req_ready` returns turn_off+1 cycles after the last sample. Requests presented while busy start nothing and raise no error.
- R9: `a_lo` starts at address bits [2:0] and steps by one per beat, wrapping modulo 8. The value for beat k (k ≥ 1) appears badr_skew cycles before that beat's sample.
- R10: A request in idle to a chip select whose stored values break rd_setup < acc_first, rd_hold < turn_off or badr_skew < acc_next raises `req_err` in that same cycle, and nothing starts. All stored values reset to 0, so an unprogrammed chip select is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write the timing values below for `cfg_cs` |
| cfg_cs | input | CSW | Chip select whose timing is written |
| cfg_acc_first | input | TW | Cycles from strobe negation to first sample |
| cfg_acc_next | input | TW | Cycles between burst samples |
| cfg_rd_setup | input | TW | Cycles from chip select to output enable |
| cfg_rd_hold | input | TW | Chip-select hold after last sample |
| cfg_turn_off | input | TW | Bus idle gap after last sample |
| cfg_badr_skew | input | TW | Lead of low address bits over a sample |
| req_valid | input | 1 | Read request present |
| req_cs | input | CSW | Chip select of the request |
| req_addr | input | DW | Start address |
| req_beats_m1 | input | 3 | Burst length minus one |
| req_ready | output | 1 | Idle, a request can be taken |
| req_err | output | 1 | Request refused for bad timing |
| ale_n | output | 1 | Address-latch strobe, active low |
| cs_n | output | NCS | Chip selects, active low |
| oe_n | output | 1 | Output enable, active low |
| a_lo | output | 3 | Low address bits |
| ad_out | output | DW | Address driven onto the shared bus |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | DW | Data from the shared bus |
| rd_valid | output | 1 | Sample pulse |
| rd_data | output | DW | Sampled data |

## Verification
The bench goes after the minimum timing (one-cycle access, zero setup and hold), the largest values, an eight-beat burst whose low address bits wrap past 7, and skews equal to acc_next−1. A design that reused one counter for output-enable and chip-select release would release both together and break R6 or R7. An off-by-one in the turn-off count would move `req_ready` a cycle early. Requests held high through the whole transfer would start a second strobe in a design that does not gate acceptance. Each of the three ordering violations is offered on its own, and a checker that missed one would start a transfer instead of flagging it.

// File: rtl/par_rd_seq.sv
module par_rd_seq #(
  parameter int DW  = 16,
  parameter int NCS = 4,
  parameter int TW  = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CSW-1:0]  cfg_cs,
  input  logic [TW-1:0]   cfg_acc_first,
  input  logic [TW-1:0]   cfg_acc_next,
  input  logic [TW-1:0]   cfg_rd_setup,
  input  logic [TW-1:0]   cfg_rd_hold,
  input  logic [TW-1:0]   cfg_turn_off,
  input  logic [TW-1:0]   cfg_badr_skew,
  input  logic            req_valid,
  input  logic [CSW-1:0]  req_cs,
  input  logic [DW-1:0]   req_addr,
  input  logic [2:0]      req_beats_m1,
  output logic            req_ready,
  output logic            req_err,
  output logic            ale_n,
  output logic [NCS-1:0]  cs_n,
  output logic            oe_n,
  output logic [2:0]      a_lo,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  input  logic [DW-1:0]   ad_in,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data
);
  localparam int CW = TW + 1;

  typedef enum logic [1:0] {IDLE, FIRST, NEXT, TAIL} st_e;

  logic [TW-1:0] r_first [NCS];
  logic [TW-1:0] r_next  [NCS];
  logic [TW-1:0] r_setup [NCS];
  logic [TW-1:0] r_hold  [NCS];
  logic [TW-1:0] r_off   [NCS];
  logic [TW-1:0] r_skew  [NCS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCS; i++) begin
        r_first[i] <= '0;
        r_next[i]  <= '0;
        r_setup[i] <= '0;
        r_hold[i]  <= '0;
        r_off[i]   <= '0;
        r_skew[i]  <= '0;
      end
    end else if (cfg_we) begin
      r_first[cfg_cs] <= cfg_acc_first;
      r_next[cfg_cs]  <= cfg_acc_next;
      r_setup[cfg_cs] <= cfg_rd_setup;
      r_hold[cfg_cs]  <= cfg_rd_hold;
      r_off[cfg_cs]   <= cfg_turn_off;
      r_skew[cfg_cs]  <= cfg_badr_skew;
    end
  end

  st_e            st;
  logic [CW-1:0]  t;
  logic [2:0]     beat, l_last, l_base;
  logic [DW-1:0]  l_addr;
  logic [CSW-1:0] l_cs;
  logic [TW-1:0]  l_first, l_next, l_setup, l_hold, l_off, l_skew;

  logic cs_ok, accept, sample, bus_act;

  assign cs_ok  = (r_setup[req_cs] < r_first[req_cs]) &&
                  (r_hold[req_cs]  < r_off[req_cs])   &&
                  (r_skew[req_cs]  < r_next[req_cs]);
  assign req_ready = (st == IDLE);
  assign req_err   = req_valid && req_ready && !cs_ok;
  assign accept    = req_valid && req_ready && cs_ok;
  assign sample    = (st == FIRST && t == CW'(l_first) + CW'(1)) ||
                     (st == NEXT  && t == CW'(l_next));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      t       <= '0;
      beat    <= '0;
      l_last  <= '0;
      l_base  <= '0;
      l_addr  <= '0;
      l_cs    <= '0;
      l_first <= '0;
      l_next  <= '0;
      l_setup <= '0;
      l_hold  <= '0;
      l_off   <= '0;
      l_skew  <= '0;
    end else begin
      case (st)
        IDLE: if (accept) begin
          st      <= FIRST;
          t       <= '0;
          beat    <= '0;
          l_last  <= req_beats_m1;
          l_base  <= req_addr[2:0];
          l_addr  <= req_addr;
          l_cs    <= req_cs;
          l_first <= r_first[req_cs];
          l_next  <= r_next[req_cs];
          l_setup <= r_setup[req_cs];
          l_hold  <= r_hold[req_cs];
          l_off   <= r_off[req_cs];
          l_skew  <= r_skew[req_cs];
        end
        FIRST, NEXT: begin
          if (sample) begin
            t <= CW'(1);
            if (beat == l_last) st <= TAIL;
            else begin
              st   <= NEXT;
              beat <= beat + 3'd1;
            end
          end else t <= t + CW'(1);
        end
        TAIL: begin
          if (t == CW'(l_off)) st <= IDLE;
          else t <= t + CW'(1);
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign ale_n   = !(st == FIRST && t == '0);
  assign ad_oe   = (st == FIRST && t == '0);
  assign ad_out  = l_addr;
  assign bus_act = (st == FIRST) || (st == NEXT) || (st == TAIL && t <= CW'(l_hold));
  assign cs_n    = bus_act ? ~(NCS'(1) << l_cs) : '1;
  assign oe_n    = !((st == FIRST && t >= CW'(l_setup)) || st == NEXT);
  assign rd_valid = sample;
  assign rd_data  = ad_in;

  always_comb begin
    case (st)
      FIRST:   a_lo = l_base;
      NEXT:    a_lo = l_base + ((t >= CW'(l_next) - CW'(l_skew)) ? beat : beat - 3'd1);
      TAIL:    a_lo = l_base + l_last;
      default: a_lo = '0;
    endcase
  end
endmodule

module par_rd_seq_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           req_err,
  input logic           ale_n,
  input logic [NCS-1:0] cs_n,
  input logic           oe_n,
  input logic           rd_valid
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ale_n && oe_n && (&cs_n) && !rd_valid)); // R1
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_n |=> ale_n); // R2
  AST_ALE_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_n |-> ($countones(~cs_n) == 1)); // R2
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1); // R2
  AST_SAMPLE_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!oe_n && !(&cs_n))); // R3
  AST_OE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !(&cs_n)); // R5
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (req_ready && req_valid)); // R10
  AST_ERR_NOSTART: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> (ale_n && req_ready)); // R10
endmodule

bind par_rd_seq par_rd_seq_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_err(req_err), .ale_n(ale_n), .cs_n(cs_n), .oe_n(oe_n), .rd_valid(rd_valid)
);

// File: tb/par_rd_seq_bench.sv
module par_rd_seq_bench;
  localparam int CLK_P = 10;
  localparam int DW = 16, NCS = 4, TW = 4, CSW = 2;
  localparam logic [12:0] TAG = 13'h0A5C;

  typedef struct packed {
    logic [1:0]  cs;
    logic [3:0]  f, n, s, h, o, k;
    logic [2:0]  m1;
    logic [15:0] addr;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{2'd0, 4'd3,  4'd2,  4'd1,  4'd1,  4'd3,  4'd1,  3'd2, 16'h1235},
    '{2'd1, 4'd1,  4'd1,  4'd0,  4'd0,  4'd1,  4'd0,  3'd0, 16'h0007},
    '{2'd2, 4'd5,  4'd3,  4'd4,  4'd2,  4'd4,  4'd2,  3'd7, 16'h00A6},
    '{2'd3, 4'd2,  4'd4,  4'd0,  4'd3,  4'd6,  4'd0,  3'd3, 16'hBEEF},
    '{2'd0, 4'd15, 4'd15, 4'd14, 4'd14, 4'd15, 4'd14, 3'd1, 16'h4000}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [CSW-1:0] cfg_cs = '0;
  logic [TW-1:0] cfg_acc_first = '0, cfg_acc_next = '0, cfg_rd_setup = '0;
  logic [TW-1:0] cfg_rd_hold = '0, cfg_turn_off = '0, cfg_badr_skew = '0;
  logic req_valid = 0;
  logic [CSW-1:0] req_cs = '0;
  logic [DW-1:0] req_addr = '0;
  logic [2:0] req_beats_m1 = '0;
  logic req_ready, req_err, ale_n, oe_n, ad_oe, rd_valid;
  logic [NCS-1:0] cs_n;
  logic [2:0] a_lo;
  logic [DW-1:0] ad_out, ad_in, rd_data;

  assign ad_in = {TAG, a_lo};

  always #(CLK_P/2) clk = ~clk;

  par_rd_seq #(.DW(DW), .NCS(NCS), .TW(TW)) u_par_rd_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cs(cfg_cs),
    .cfg_acc_first(cfg_acc_first), .cfg_acc_next(cfg_acc_next),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_hold(cfg_rd_hold),
    .cfg_turn_off(cfg_turn_off), .cfg_badr_skew(cfg_badr_skew),
    .req_valid(req_valid), .req_cs(req_cs), .req_addr(req_addr),
    .req_beats_m1(req_beats_m1), .req_ready(req_ready), .req_err(req_err),
    .ale_n(ale_n), .cs_n(cs_n), .oe_n(oe_n), .a_lo(a_lo), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] cs, input logic [3:0] f, n, s, h, o, k);
    @(negedge clk);
    cfg_we = 1; cfg_cs = cs;
    cfg_acc_first = f; cfg_acc_next = n; cfg_rd_setup = s;
    cfg_rd_hold = h; cfg_turn_off = o; cfg_badr_skew = k;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run_vec(input vec_t v);
    int sk [8];
    int nb, last, ale_cnt, bad_ad, bad_err, oe_low, oe_rise, cs_rise, rdy, ns;
    nb = int'(v.m1) + 1;
    for (int k = 0; k < nb; k++) sk[k] = int'(v.f) + 1 + k * int'(v.n);
    last = sk[nb-1];
    ale_cnt = 0; bad_ad = 0; bad_err = 0; oe_low = -1; oe_rise = -1;
    cs_rise = -1; rdy = -1; ns = 0;
    cfg_write(v.cs, v.f, v.n, v.s, v.h, v.o, v.k);
    req_valid = 1; req_cs = v.cs; req_addr = v.addr; req_beats_m1 = v.m1;
    @(negedge clk);
    req_addr = v.addr ^ 16'h00F0;
    for (int c = 0; c < 200; c++) begin
      if (c == 0) begin
        chk(ad_oe && ad_out == v.addr, "R2 address phase", int'(ad_out), int'(v.addr));
        chk(cs_n == ~(4'b1 << v.cs), "R2 chip select", int'(cs_n), int'(~(4'b1 << v.cs)) & 15);
      end else if (ad_oe) bad_ad++;
      if (!ale_n) begin
        ale_cnt++;
        if (c != 0) bad_ad++;
      end
      if (req_err) bad_err++;
      if (!oe_n && oe_low < 0) oe_low = c;
      if (oe_n && oe_low >= 0 && oe_rise < 0) oe_rise = c;
      if (c > 0 && (&cs_n) && cs_rise < 0) cs_rise = c;
      if (rd_valid) begin
        if (ns < nb) begin
          chk(c == sk[ns], ns == 0 ? "R3 first sample cycle" : "R4 beat spacing", c, sk[ns]);
          chk(rd_data == {TAG, 3'(v.addr[2:0] + 3'(ns))}, "R3 sampled data",
              int'(rd_data), int'({TAG, 3'(v.addr[2:0] + 3'(ns))}));
        end
        ns++;
      end
      for (int k = 1; k < nb; k++) begin
        if (c == sk[k] - int'(v.k))
          chk(a_lo == 3'(v.addr[2:0] + 3'(k)), "R9 low address new", int'(a_lo), int'(3'(v.addr[2:0] + 3'(k))));
        if (c == sk[k] - int'(v.k) - 1)
          chk(a_lo == 3'(v.addr[2:0] + 3'(k - 1)), "R9 low address old", int'(a_lo), int'(3'(v.addr[2:0] + 3'(k - 1))));
      end
      if (req_ready) begin
        req_valid = 0;
        rdy = c;
        break;
      end
      @(negedge clk);
    end
    chk(ns == nb, "R4 beat count", ns, nb);
    chk(ale_cnt == 1 && bad_ad == 0, "R8 busy request ignored", ale_cnt, 1);
    chk(bad_err == 0, "R8 no error while busy", bad_err, 0);
    chk(oe_low == int'(v.s), "R5 output enable setup", oe_low, int'(v.s));
    chk(oe_rise == last + 1, "R6 output enable release", oe_rise, last + 1);
    chk(cs_rise == last + int'(v.h) + 1, "R7 chip select hold", cs_rise, last + int'(v.h) + 1);
    chk(rdy == last + int'(v.o) + 1, "R8 turn-off gap", rdy, last + int'(v.o) + 1);
  endtask

  task automatic try_bad(input logic [1:0] cs, input string what);
    @(negedge clk);
    req_valid = 1; req_cs = cs; req_addr = 16'h0011; req_beats_m1 = 3'd0;
    #(CLK_P/4);
    chk(req_err == 1'b1, what, int'(req_err), 1);
    @(negedge clk);
    req_valid = 0;
    chk(ale_n && req_ready && (&cs_n), "R10 refused request not started", int'(ale_n), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && ale_n && oe_n && (&cs_n) && !ad_oe && !rd_valid, "R1 reset state", int'(req_ready), 1);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && ale_n && oe_n && (&cs_n) && !ad_oe, "R1 idle after reset", int'(cs_n), 15);
    try_bad(2'd2, "R10 unprogrammed chip select");

    for (int i = 0; i < 5; i++) run_vec(VEC[i]);

    cfg_write(2'd1, 4'd2, 4'd2, 4'd2, 4'd0, 4'd1, 4'd0);
    try_bad(2'd1, "R10 setup not below first access");
    cfg_write(2'd1, 4'd2, 4'd2, 4'd1, 4'd1, 4'd1, 4'd0);
    try_bad(2'd1, "R10 hold not below turn-off");
    cfg_write(2'd1, 4'd2, 4'd2, 4'd0, 4'd0, 4'd1, 4'd2);
    try_bad(2'd1, "R10 skew not below beat spacing");

    cfg_write(2'd1, 4'd2, 4'd2, 4'd1, 4'd0, 4'd1, 4'd1);
    @(negedge clk);
    req_valid = 1; req_cs = 2'd1; req_addr = 16'h0003; req_beats_m1 = 3'd0;
    #(CLK_P/4);
    chk(req_err == 1'b0, "R10 valid timing accepted", int'(req_err), 0);
    @(negedge clk);
    req_valid = 0;
    chk(!ale_n, "R2 strobe after valid request", int'(ale_n), 0);
    repeat (10) @(negedge clk);
    chk(req_ready && oe_n && (&cs_n), "R1 idle after short read", int'(req_ready), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule